// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block carries out one complete NAND flash operation each time software writes a start word into its first control register. The operation runs as a fixed order of phases: an opcode byte with the command latch line raised, zero to five address bytes with the address latch line raised, an optional data phase in which bytes are either read from or written to the flash, and an optional second opcode. The sequencer then waits a fixed settling interval, watches the ready/busy line until the device is ready, and raises completion flags that software clears by writing ones.

Software loads the address, length and second-opcode registers first, then writes the start word. Program and erase pairs, and a read with a read-start opcode, therefore need only one start write. Write data comes from a byte-wide source that the block pops one byte at a time. Read data goes to a byte-wide sink that the block pushes one byte at a time. Strobe widths and the settling interval come from fixed cycle counts set by parameters.

Top module: `nand_op_seq`

## Requirements
- R1: A write to register 0 with bit 31 set, made while idle, starts an operation. Status register 2 bit 0 reads 1 until the operation ends. The first bus byte is register 0 bits 7:0, driven with CLE high and latched by one WE# low pulse.
- R2: Register 0 bit 19 picks the chip enable. When it is 1, `nd_ce_n` is 2'b01 during the whole operation. When it is 0, `nd_ce_n` is 2'b10. When idle, `nd_ce_n` is 2'b11.
- R3: When register 0 bit 30 is set, the number of address bytes is bits 29:27 plus one, limited to five. When bit 30 is clear, no address bytes are sent. Address bytes go out with ALE high, lowest byte first: register 5 bits 15:0, then register 6 bits 23:0.
- R4: Register 0 bit 26 requests a read phase. After the ready wait, the block strobes RE# once per byte and passes each byte to the sink in order. If bits 26 and 25 are both set, the operation is a read.
- R5: Register 0 bit 25 (with bit 26 clear) requests a write phase. The block puts source bytes on the bus with WE# strobes and pops the source once per byte. With neither bit set, there is no data phase.
- R6: Register 1 bit 8, as it stands at start, enables a second opcode taken from register 1 bits 7:0, driven with CLE high. For reads and for operations without data, it follows the address bytes. For writes, it follows the data.
- R7: Register 4 holds the exact number of data bytes. A length of 0 gives no data strobes.
- R8: After the last command, address or data byte, the block waits TWB cycles and then until `nd_rb` is high. Only then does it set register 3 bit 31 (command done). While `nd_rb` stays low, bit 31 stays 0 and busy stays 1.
- R9: Register 3 bit 28 (data done) is set when the data phase of a read or write ends, including one of length 0. It is never set for an operation with no data phase. Writing 1 to bit 31 or bit 28 clears that bit alone.
- R10: A write to register 0 while busy is ignored: register 0 reads back unchanged and no extra bus cycle occurs.
- R11: After reset, status, flags and control read 0, both chip enables and both strobes are high, and CLE and ALE are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 ctrl, 1 second opcode, 2 status, 3 flags, 4 length, 5 addr low, 6 addr high) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| nd_dq_out | output | 8 | Flash bus outgoing byte |
| nd_dq_oe | output | 1 | Flash bus output enable |
| nd_dq_in | input | 8 | Flash bus incoming byte |
| nd_cle | output | 1 | Command latch enable |
| nd_ale | output | 1 | Address latch enable |
| nd_we_n | output | 1 | Write strobe, active low |
| nd_re_n | output | 1 | Read strobe, active low |
| nd_ce_n | output | 2 | Chip enables, active low |
| nd_rb | input | 1 | Ready (1) / busy (0) from the flash |
| src_byte | input | 8 | Next byte to be written |
| src_take | output | 1 | Pulse: source byte consumed |
| snk_byte | output | 8 | Byte read from the flash |
| snk_put | output | 1 | Pulse: snk_byte valid |

## Verification
A phase counter or state decode that goes wrong shows up on the bus within one byte slot. A byte appears with the wrong latch line, in the wrong order, or one too many or too few, and the scoreboard catches the mismatch at that WE# rising edge or sink push. A wrong length or address-count register shows up as a missing or extra strobe before the flags are read. A wrong ready-wait shows up as the command-done flag rising while `nd_rb` is held low. A wrong chip-select latch is visible on `nd_ce_n` a few cycles after start.

// File: rtl/nand_op_seq.sv
module nand_op_seq #(
  parameter int HALF = 2,
  parameter int TWB  = 6,
  parameter int LW   = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [7:0]  nd_dq_out,
  output logic        nd_dq_oe,
  input  logic [7:0]  nd_dq_in,
  output logic        nd_cle,
  output logic        nd_ale,
  output logic        nd_we_n,
  output logic        nd_re_n,
  output logic [1:0]  nd_ce_n,
  input  logic        nd_rb,
  input  logic [7:0]  src_byte,
  output logic        src_take,
  output logic [7:0]  snk_byte,
  output logic        snk_put
);
  localparam int CW = $clog2(((2*HALF > TWB) ? 2*HALF : TWB) + 1);
  localparam logic [CW-1:0] BYTE_END = CW'(2*HALF-1);
  localparam logic [CW-1:0] MID      = CW'(HALF-1);
  localparam logic [CW-1:0] LOW_END  = CW'(HALF);
  localparam logic [CW-1:0] WB_END   = CW'(TWB-1);

  typedef enum logic [2:0] {S_IDLE, S_C1, S_AD, S_C2, S_RD, S_WR, S_WT} st_t;
  st_t st, st_nx, after_ad;

  logic [CW-1:0] cnt;
  logic [31:0]   ctrl1_q, ctrl2_q;
  logic [LW-1:0] dlen_q, left;
  logic [15:0]   a1_q;
  logic [23:0]   a2_q;
  logic [2:0]    na, idx;
  logic          c2en, irq_cmd, irq_dat, cmd_set, dat_set;
  logic [7:0]    c2op;

  wire busy     = st != S_IDLE;
  wire op_rd    = ctrl1_q[26];
  wire op_wr    = ctrl1_q[25] & ~ctrl1_q[26];
  wire start    = reg_we && reg_addr == 3'd0 && reg_wdata[31] && !busy;
  wire byte_end = cnt == BYTE_END;
  wire irq_wr   = reg_we && reg_addr == 3'd3;
  wire [2:0] na_code = reg_wdata[29:27];
  wire [2:0] na_new  = !reg_wdata[30] ? 3'd0 : (na_code >= 3'd4) ? 3'd5 : na_code + 3'd1;
  wire [39:0] addr_sh = {a2_q, a1_q} >> {idx, 3'b000};
  wire wr_like  = st == S_C1 || st == S_C2 || st == S_AD || st == S_WR;

  assign nd_cle   = st == S_C1 || st == S_C2;
  assign nd_ale   = st == S_AD;
  assign nd_dq_oe = wr_like;
  assign nd_we_n  = !(wr_like && cnt < LOW_END);
  assign nd_re_n  = !(st == S_RD && cnt < LOW_END);
  assign nd_ce_n  = !busy ? 2'b11 : (ctrl1_q[19] ? 2'b01 : 2'b10);
  assign src_take = st == S_WR && byte_end;

  always_comb begin
    case (st)
      S_C1:    nd_dq_out = ctrl1_q[7:0];
      S_C2:    nd_dq_out = c2op;
      S_AD:    nd_dq_out = addr_sh[7:0];
      S_WR:    nd_dq_out = src_byte;
      default: nd_dq_out = 8'h00;
    endcase
  end

  always_comb begin
    if (op_rd)                    after_ad = c2en ? S_C2 : S_WT;
    else if (op_wr && left != '0) after_ad = S_WR;
    else                          after_ad = c2en ? S_C2 : S_WT;
  end

  always_comb begin
    st_nx = st;
    cmd_set = 1'b0;
    dat_set = 1'b0;
    case (st)
      S_IDLE: if (start) st_nx = S_C1;
      S_C1: if (byte_end) begin
        st_nx = (na != 3'd0) ? S_AD : after_ad;
        if (na == 3'd0 && op_wr && left == '0) dat_set = 1'b1;
      end
      S_AD: if (byte_end && idx == na - 3'd1) begin
        st_nx = after_ad;
        if (op_wr && left == '0) dat_set = 1'b1;
      end
      S_C2: if (byte_end) st_nx = S_WT;
      S_WR: if (byte_end && left == LW'(1)) begin
        dat_set = 1'b1;
        st_nx = c2en ? S_C2 : S_WT;
      end
      S_WT: if (cnt == WB_END && nd_rb) begin
        cmd_set = 1'b1;
        if (op_rd && left != '0) st_nx = S_RD;
        else begin
          st_nx = S_IDLE;
          dat_set = op_rd;
        end
      end
      S_RD: if (byte_end && left == LW'(1)) begin
        dat_set = 1'b1;
        st_nx = S_IDLE;
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      ctrl1_q <= '0;
      ctrl2_q <= '0;
      dlen_q <= '0;
      left <= '0;
      a1_q <= '0;
      a2_q <= '0;
      na <= '0;
      idx <= '0;
      c2en <= 1'b0;
      c2op <= '0;
      irq_cmd <= 1'b0;
      irq_dat <= 1'b0;
      snk_byte <= '0;
      snk_put <= 1'b0;
    end else begin
      st <= st_nx;
      if (st_nx != st) cnt <= '0;
      else if (st == S_WT) begin
        if (cnt != WB_END) cnt <= cnt + 1'b1;
      end else if (busy) cnt <= byte_end ? '0 : cnt + 1'b1;
      if (start) begin
        ctrl1_q <= reg_wdata;
        na <= na_new;
        idx <= '0;
        c2en <= ctrl2_q[8];
        c2op <= ctrl2_q[7:0];
        left <= dlen_q;
      end
      if (st == S_AD && byte_end) idx <= idx + 3'd1;
      if ((st == S_WR || st == S_RD) && byte_end) left <= left - 1'b1;
      snk_put <= st == S_RD && cnt == MID;
      if (st == S_RD && cnt == MID) snk_byte <= nd_dq_in;
      if (reg_we && reg_addr == 3'd1) ctrl2_q <= reg_wdata;
      if (reg_we && reg_addr == 3'd4) dlen_q <= reg_wdata[LW-1:0];
      if (reg_we && reg_addr == 3'd5) a1_q <= reg_wdata[15:0];
      if (reg_we && reg_addr == 3'd6) a2_q <= reg_wdata[23:0];
      irq_cmd <= cmd_set | (irq_cmd & ~(irq_wr & reg_wdata[31]));
      irq_dat <= dat_set | (irq_dat & ~(irq_wr & reg_wdata[28]));
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = ctrl1_q;
      3'd1:    reg_rdata = ctrl2_q;
      3'd2:    reg_rdata = {31'd0, busy};
      3'd3:    reg_rdata = {irq_cmd, 2'b00, irq_dat, 28'd0};
      3'd4:    reg_rdata = 32'(dlen_q);
      3'd5:    reg_rdata = {16'd0, a1_q};
      3'd6:    reg_rdata = {8'd0, a2_q};
      default: reg_rdata = 32'd0;
    endcase
  end

  assert_latch_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(nd_cle && nd_ale));
  assert_ce_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $countones(~nd_ce_n) == 1);
  assert_ce_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> nd_ce_n == 2'b11);
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nd_we_n && !nd_re_n));
  assert_done_after_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_cmd) |-> $past(nd_rb));
  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_addr == 3'd0) |=> $stable(ctrl1_q));
endmodule

// File: tb/nand_op_seq_test.sv
`timescale 1ns/1ps
module nand_op_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [7:0] nd_dq_out, nd_dq_in, src_byte, snk_byte;
  logic nd_dq_oe, nd_cle, nd_ale, nd_we_n, nd_re_n, nd_rb = 1'b1, src_take, snk_put;
  logic [1:0] nd_ce_n;

  int checks = 0, fails = 0;
  int rcnt = 0, wcnt = 0, rexp = 0, wexp = 0;
  logic prev_we = 1'b1, prev_re = 1'b1;
  logic [9:0] q[$];

  always #2.5 clk = ~clk;

  assign nd_dq_in = 8'hA0 + 8'(rcnt);
  assign src_byte = 8'h50 + 8'(wcnt);

  nand_op_seq uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // kinds: 0 command, 1 address, 2 write data, 3 read data to sink
  task automatic push(input logic [1:0] k, input logic [7:0] b);
    q.push_back({k, b});
  endtask
  task automatic exp_wr(input int n);
    for (int i = 0; i < n; i++) begin push(2'd2, 8'h50 + 8'(wexp)); wexp++; end
  endtask
  task automatic exp_rd(input int n);
    for (int i = 0; i < n; i++) begin push(2'd3, 8'hA0 + 8'(rexp)); rexp++; end
  endtask

  task automatic monitor_event(input logic [1:0] k, input logic [7:0] b);
    logic [9:0] e;
    checks++;
    if (q.size() == 0) begin
      fails++;
      $display("FAIL R1/R10 unexpected bus event actual=%h expected=none", {k, b});
    end else begin
      e = q.pop_front();
      if (e !== {k, b}) begin
        fails++;
        $display("FAIL R3/R4/R5/R6 bus event actual=%h expected=%h", {k, b}, e);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!prev_we && nd_we_n) monitor_event(nd_cle ? 2'd0 : nd_ale ? 2'd1 : 2'd2, nd_dq_out);
      if (snk_put) monitor_event(2'd3, snk_byte);
      if (!prev_re && nd_re_n) rcnt++;
      if (src_take) wcnt++;
    end
    prev_we = nd_we_n;
    prev_re = nd_re_n;
  end

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask
  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask
  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rreg(3'd2, s);
      if (s[0] == 1'b0) return;
    end
    chk("R8 wait idle", 32'd1, 32'd0);
  endtask
  task automatic setup(input logic [31:0] c2, input int len, input logic [31:0] a1, input logic [31:0] a2);
    wreg(3'd1, c2); wreg(3'd4, len); wreg(3'd5, a1); wreg(3'd6, a2);
  endtask
  task automatic end_op(input string req, input logic [31:0] irq_exp);
    logic [31:0] d;
    wait_idle();
    repeat (2) @(negedge clk);
    chk({req, " queue drained"}, q.size(), 0);
    rreg(3'd3, d);
    chk({req, " flags"}, d, irq_exp);
    wreg(3'd3, 32'h9000_0000);
    rreg(3'd3, d);
    chk("R9 flags cleared", d, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", checks + 1, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    rreg(3'd2, d); chk("R11 status", d, 0);
    rreg(3'd3, d); chk("R11 flags", d, 0);
    rreg(3'd0, d); chk("R11 ctrl", d, 0);
    chk("R11 pins", {nd_ce_n, nd_we_n, nd_re_n, nd_cle, nd_ale}, 6'b111100);

    // R1 R3 R4 R6: read, 5 address bytes, read-start opcode, chip 0
    setup(32'h130, 4, 32'h1234, 32'h56789A);
    push(0, 8'h00); push(1, 8'h34); push(1, 8'h12); push(1, 8'h9A); push(1, 8'h78); push(1, 8'h56);
    push(0, 8'h30); exp_rd(4);
    wreg(3'd0, 32'hE400_0000);
    rreg(3'd2, d); chk("R1 busy", d, 1);
    chk("R2 ce chip0", nd_ce_n, 2'b10);
    end_op("R4", 32'h9000_0000);

    // R5 R6 R2: write to chip 1, 2 address bytes, program opcode after data
    setup(32'h110, 3, 32'hBEEF, 32'h0);
    push(0, 8'h80); push(1, 8'hEF); push(1, 8'hBE); exp_wr(3); push(0, 8'h10);
    wreg(3'd0, 32'hCA08_0080);
    repeat (3) @(negedge clk);
    chk("R2 ce chip1", nd_ce_n, 2'b01);
    end_op("R5", 32'h9000_0000);

    // R8 R10 R9: erase-style op with no data, R/B# held low
    setup(32'h1D0, 0, 32'h4321, 32'h0A);
    push(0, 8'h60); push(1, 8'h21); push(1, 8'h43); push(1, 8'h0A); push(0, 8'hD0);
    nd_rb = 1'b0;
    wreg(3'd0, 32'hD000_0060);
    repeat (150) @(negedge clk);
    rreg(3'd3, d); chk("R8 no done while busy line low", d, 0);
    rreg(3'd2, d); chk("R8 still busy", d, 1);
    wreg(3'd0, 32'h8400_0070);
    rreg(3'd0, d); chk("R10 ctrl unchanged", d, 32'hD000_0060);
    nd_rb = 1'b1;
    end_op("R9 no data", 32'h8000_0000);

    // R3 address absent, R6 disabled, 1-byte read
    setup(32'h030, 1, 32'h0, 32'h0);
    push(0, 8'h70); exp_rd(1);
    wreg(3'd0, 32'h8400_0070);
    end_op("R3 no address", 32'h9000_0000);

    // R3 clamp to five bytes
    setup(32'h0, 0, 32'hA1B2, 32'hC3D4E5);
    push(0, 8'h90); push(1, 8'hB2); push(1, 8'hA1); push(1, 8'hE5); push(1, 8'hD4); push(1, 8'hC3);
    wreg(3'd0, 32'hF800_0090);
    end_op("R3 clamp", 32'h8000_0000);

    // R7 zero-length read: no strobes, data-done still set
    setup(32'h0, 0, 32'h0, 32'h0);
    push(0, 8'h05);
    wreg(3'd0, 32'h8400_0005);
    end_op("R7 zero length", 32'h9000_0000);

    // R4 both data bits set -> read of 2 bytes; R9 partial clear
    setup(32'h0, 2, 32'h0, 32'h0);
    push(0, 8'h00); exp_rd(2);
    wreg(3'd0, 32'h8600_0000);
    wait_idle();
    wreg(3'd3, 32'h1000_0000);
    rreg(3'd3, d); chk("R9 clear data-done only", d, 32'h8000_0000);
    end_op("R4 read priority", 32'h8000_0000);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule